// File: doc/BRIEF.md
# SPI Mode-3 Register Access Slave

This block connects an external SPI master to a map of 16-bit registers on a synchronous register bus. The master sends 16-bit frames with the clock idling high. Data is sampled on rising SCLK edges and launched on falling edges. Each frame holds a direction bit, a 7-bit byte address and one data byte. A write frame updates a single byte lane of a register. A read frame asks for a whole 16-bit register, and that word is shifted out during the next frame. Because the answer always trails the request by one frame, a master can stream requests and collect the answers in full duplex.

CS, SCLK and DIN are brought into the system clock domain through synchronizers. All decoding happens on system clock edges. The block classifies every byte address in three ways:
- whether it may be written on the bus;
- whether it is read over the bus;
- whether it is answered locally, with a fixed identification word or with zero.

Any transfer whose clock count is not a multiple of 16 sets a sticky failure flag. That flag feeds the SPI-failure bit of a status word kept elsewhere, and the status logic clears it.

Top module: `spi_reg_slave`

## Requirements
- R1: SPI mode 3, MSB first. DIN is taken on SCLK rising edges and DOUT changes on SCLK falling edges. `spi_dout_oe_o` is 1 only while CS is low, so the pad is high impedance while CS is high.
- R2: A frame with bit 15 = 1 is a write. Bits 14:8 are the byte address and bits 7:0 are the data. For a writable address (0x12–0x17, 0x20–0x2F, 0x32–0x3B, 0x3E–0x3F) this gives exactly one `reg_we_o` pulse, carrying that address and that byte. An even address selects register bits 7:0 and an odd address selects bits 15:8.
- R3: A frame with bit 15 = 0 is a read request. For a bus-readable address (0x00–0x17, 0x20–0x2F, 0x32–0x3D, 0x52–0x55, 0x58–0x59) it gives one `reg_re_o` pulse. The 16-bit word on `reg_rdata_i` in the cycle after that pulse is shifted out during the next frame.
- R4: Read requests sent back to back each return the word asked for by the frame before.
- R5: The frame after a write frame shifts out 0x0000, and so does the first frame after reset.
- R6: A read request to 0x56 or 0x57 returns the parameter `ID_VALUE` (default 0x3F52) in the next frame, with no bus read.
- R7: A write to any address outside the writable set (read-only, reserved or identification) gives no `reg_we_o` pulse and leaves the registers unchanged.
- R8: A read request to an address that is neither bus-readable nor the identification word (for example 0x30, 0x3E, 0x7E) gives no `reg_re_o` and returns 0x0000 in the next frame.
- R9: When CS rises after a number of SCLK rising edges that is not a multiple of 16, `err_o` is set. A partial trailing frame causes no bus access.
- R10: `err_o` stays set through later well-formed transfers until `err_clr_i` is pulsed, which clears it.
- R11: Several 16-bit frames inside one CS-low period are handled as separate frames and do not set `err_o`.
- R12: After reset, `err_o`, `spi_dout_oe_o`, `reg_we_o` and `reg_re_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_sclk_i | input | 1 | Serial clock, idles high |
| spi_din_i | input | 1 | Serial data from master |
| spi_dout_o | output | 1 | Serial data to master |
| spi_dout_oe_o | output | 1 | Output enable for the DOUT pad |
| reg_we_o | output | 1 | Byte write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_addr_o | output | 7 | Byte address of the access |
| reg_wdata_o | output | 8 | Write byte |
| reg_rdata_i | input | 16 | Read word, valid the cycle after `reg_re_o` |
| err_clr_i | input | 1 | Clears the sticky frame-length flag |
| err_o | output | 1 | Sticky frame-length failure flag |

## Verification
The hardest situation to reach is a CS-low period whose clock count is not a multiple of 16. Such a period may contain a complete frame followed by a stray tail, and the complete frame must still act while the tail must not. The bench's serial task takes an arbitrary bit count. It sends 10-, 12- and 17-bit transfers and one 32-bit transfer, and checks the flag and the bus strobe counts after each. The one-frame read latency is followed by chaining requests and comparing each returned word with the bench's own register model for the request before.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    AC_RSVD = 2'd0,
    AC_RO   = 2'd1,
    AC_RW   = 2'd2,
    AC_WO   = 2'd3
  } acc_e;

  // word index = byte address >> 1
  function automatic acc_e word_class(input logic [5:0] w);
    acc_e c;
    if (w <= 6'd8)       c = AC_RO;
    else if (w <= 6'd11) c = AC_RW;
    else if (w <= 6'd15) c = AC_RSVD;
    else if (w <= 6'd23) c = AC_RW;
    else if (w == 6'd24) c = AC_RSVD;
    else if (w <= 6'd29) c = AC_RW;
    else if (w == 6'd30) c = AC_RO;
    else if (w == 6'd31) c = AC_WO;
    else if (w <= 6'd40) c = AC_RSVD;
    else if (w <= 6'd44) c = AC_RO;
    else                 c = AC_RSVD;
    return c;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               sclk_i,
  input  logic               din_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               frame_done_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               err_set_o,
  output logic               dout_o,
  output logic               dout_oe_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               cs_q, sclk_q, dout_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] shf_q;
  logic               cs_fall, cs_rise, s_rise, s_fall;
  logic [CNT_W-1:0]   bit_idx;

  assign cs_fall = cs_q & ~cs_n_i;
  assign cs_rise = ~cs_q & cs_n_i;
  assign s_rise  = ~sclk_q & sclk_i & ~cs_n_i;
  assign s_fall  = sclk_q & ~sclk_i & ~cs_n_i;
  assign bit_idx = LAST - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      shf_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
      if (cs_fall)     cnt_q <= '0;
      else if (s_rise) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (s_rise) shf_q <= {shf_q[FRAME_W-3:0], din_i};
      // first bit is presented before the first falling edge
      if (cs_fall)     dout_q <= tx_word_i[FRAME_W-1];
      else if (s_fall) dout_q <= tx_word_i[bit_idx];
    end
  end

  assign frame_done_o = s_rise & (cnt_q == LAST);
  assign frame_o      = {shf_q, din_i};
  assign err_set_o    = cs_rise & (cnt_q != '0);
  assign dout_o       = dout_q;
  assign dout_oe_o    = ~cs_q;

endmodule

// File: rtl/spi_reg_dec.sv
module spi_reg_dec #(
  parameter int unsigned ADDR_W  = 7,
  parameter logic [ADDR_W-1:0] ID_ADDR = 7'h56
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_ok_o,
  output logic              rd_ext_o,
  output logic              rd_id_o
);
  import spi_reg_pkg::*;

  acc_e cls;
  logic is_id;

  assign cls   = word_class(6'(addr_i[ADDR_W-1:1]));
  assign is_id = addr_i[ADDR_W-1:1] == ID_ADDR[ADDR_W-1:1];

  assign wr_ok_o  = ~is_id & ((cls == AC_RW) | (cls == AC_WO));
  assign rd_ext_o = ~is_id & ((cls == AC_RW) | (cls == AC_RO));
  assign rd_id_o  = is_id;

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ID_ADDR = 7'h56,
  parameter logic [2*(FRAME_W-1-ADDR_W)-1:0] ID_VALUE = 16'h3F52
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                spi_cs_ni,
  input  logic                spi_sclk_i,
  input  logic                spi_din_i,
  output logic                spi_dout_o,
  output logic                spi_dout_oe_o,
  output logic                reg_we_o,
  output logic                reg_re_o,
  output logic [ADDR_W-1:0]   reg_addr_o,
  output logic [FRAME_W-1-ADDR_W-1:0] reg_wdata_o,
  input  logic [2*(FRAME_W-1-ADDR_W)-1:0] reg_rdata_i,
  input  logic                err_clr_i,
  output logic                err_o
);

  localparam int unsigned DATA_W = FRAME_W - 1 - ADDR_W;
  localparam int unsigned REG_W  = 2 * DATA_W;

  logic               cs_s, sclk_s, din_s;
  logic               frame_done, err_set;
  logic [FRAME_W-1:0] frame;
  logic [REG_W-1:0]   tx_q;
  logic               rw;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  data;
  logic               wr_ok, rd_ext, rd_id;
  logic               we_q, re_q, rsp_q, err_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;

  spi_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({spi_cs_ni, spi_sclk_i, spi_din_i}),
    .q_o    ({cs_s, sclk_s, din_s})
  );

  spi_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_n_i       (cs_s),
    .sclk_i       (sclk_s),
    .din_i        (din_s),
    .tx_word_i    (FRAME_W'(tx_q)),
    .frame_done_o (frame_done),
    .frame_o      (frame),
    .err_set_o    (err_set),
    .dout_o       (spi_dout_o),
    .dout_oe_o    (spi_dout_oe_o)
  );

  assign rw   = frame[FRAME_W-1];
  assign addr = frame[FRAME_W-2 -: ADDR_W];
  assign data = frame[DATA_W-1:0];

  spi_reg_dec #(.ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR)) u_dec (
    .addr_i   (addr),
    .wr_ok_o  (wr_ok),
    .rd_ext_o (rd_ext),
    .rd_id_o  (rd_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      rsp_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      tx_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      we_q  <= frame_done & rw & wr_ok;
      re_q  <= frame_done & ~rw & rd_ext;
      rsp_q <= re_q;
      if (frame_done) begin
        addr_q  <= addr;
        wdata_q <= data;
      end
      // answer for the next frame
      if (frame_done & rw)            tx_q <= '0;
      else if (frame_done & ~rd_ext)  tx_q <= rd_id ? ID_VALUE : '0;
      else if (rsp_q)                 tx_q <= reg_rdata_i;
      // set has priority over clear
      if (err_set)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign err_o       = err_q;

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_cs_ni,
  input logic spi_dout_oe_o,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic err_clr_i,
  input logic err_o,
  input logic err_set
);

  logic [2:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 7)  cyc_q <= cyc_q + 1'b1;
  end

  p_oe_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 3'd7 && spi_cs_ni && $past(spi_cs_ni) && $past(spi_cs_ni, 2)
     && $past(spi_cs_ni, 3)) |-> !spi_dout_oe_o);

  p_we_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_re_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  p_we_re_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 3'd0 && $rose(err_o)) |-> $past(err_set));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .spi_cs_ni     (spi_cs_ni),
  .spi_dout_oe_o (spi_dout_oe_o),
  .reg_we_o      (reg_we_o),
  .reg_re_o      (reg_re_o),
  .err_clr_i     (err_clr_i),
  .err_o         (err_o),
  .err_set       (err_set)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0, err_clr = 1'b0;
  logic dout, dout_oe, we, re, err;
  logic [6:0]  addr;
  logic [7:0]  wdata;
  logic [15:0] rdata = '0;

  logic [15:0] mem [64];
  int we_cnt = 0, re_cnt = 0;
  int checks = 0, errors = 0;
  logic [6:0] last_we_addr;
  logic [7:0] last_we_data;
  logic oe_mid;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_cs_ni(cs_n), .spi_sclk_i(sclk), .spi_din_i(din),
    .spi_dout_o(dout), .spi_dout_oe_o(dout_oe),
    .reg_we_o(we), .reg_re_o(re), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata), .err_clr_i(err_clr), .err_o(err)
  );

  initial for (int w = 0; w < 64; w++) mem[w] = 16'((w * 16'h0123) ^ 16'hA5C3);

  // register-file model
  always @(posedge clk) begin
    if (re) begin
      rdata <= mem[addr[6:1]];
      re_cnt <= re_cnt + 1;
    end
    if (we) begin
      if (addr[0]) mem[addr[6:1]][15:8] <= wdata;
      else         mem[addr[6:1]][7:0]  <= wdata;
      last_we_addr <= addr;
      last_we_data <= wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2*HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din  = tx[31-i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      rx[31-i] = dout;
      if (i == 0) oe_mid = dout_oe;
      repeat (HALF) @(negedge clk);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic f16(input logic [15:0] w, output logic [15:0] r);
    logic [31:0] rx;
    xfer({w, 16'h0}, 16, rx);
    r = rx[31:16];
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk(err == 0, "R12 err", 32'(err), 0);
    chk(dout_oe == 0, "R12 oe", 32'(dout_oe), 0);
    chk(we == 0 && re == 0, "R12 strobes", {30'b0, we, re}, 0);
    f16(16'h0400, r);
    chk(r == 16'h0000, "R5 first frame after reset", 32'(r), 0);
    chk(oe_mid == 1'b1, "R1 oe while cs low", 32'(oe_mid), 1);
    chk(dout_oe == 1'b0, "R1 oe after cs high", 32'(dout_oe), 0);
  endtask

  task automatic t_write_read;
    logic [15:0] r;
    int w0 = we_cnt, r0;
    f16(16'h925A, r);
    chk(we_cnt == w0 + 1, "R2 we count", 32'(we_cnt), 32'(w0 + 1));
    chk(last_we_addr == 7'h12 && last_we_data == 8'h5A, "R2 addr/data",
        {16'(last_we_addr), 16'(last_we_data)}, {16'h12, 16'h5A});
    f16(16'h93C3, r);
    chk(last_we_addr == 7'h13 && last_we_data == 8'hC3, "R2 odd lane",
        {16'(last_we_addr), 16'(last_we_data)}, {16'h13, 16'hC3});
    r0 = re_cnt;
    f16(16'h1200, r);
    chk(re_cnt == r0 + 1, "R3 re count", 32'(re_cnt), 32'(r0 + 1));
    f16(16'h0000, r);
    chk(r == 16'hC35A, "R3 read word", 32'(r), 32'h0000C35A);
  endtask

  task automatic t_pipelined;
    logic [15:0] r;
    logic [15:0] req [4] = '{16'h0600, 16'h0800, 16'h2E00, 16'h3400};
    f16(16'h0400, r);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] exp;
      exp = mem[(k == 0) ? 2 : req[k-1][14:9]];
      f16(req[k], r);
      chk(r == exp, "R4 back-to-back", 32'(r), 32'(exp));
    end
  endtask

  task automatic t_after_write;
    logic [15:0] r;
    f16(16'h0400, r);
    f16(16'h9477, r);
    chk(r == mem[2], "R4 answer during write frame", 32'(r), 32'(mem[2]));
    f16(16'h0000, r);
    chk(r == 16'h0000, "R5 zero after write", 32'(r), 0);
  endtask

  task automatic t_id;
    logic [15:0] r;
    int r0 = re_cnt;
    f16(16'h5600, r);
    chk(re_cnt == r0, "R6 no bus read", 32'(re_cnt), 32'(r0));
    f16(16'h5700, r);
    chk(r == 16'h3F52, "R6 id even", 32'(r), 32'h3F52);
    f16(16'h0000, r);
    chk(r == 16'h3F52, "R6 id odd", 32'(r), 32'h3F52);
  endtask

  task automatic t_ro_write;
    logic [15:0] r;
    logic [15:0] keep = mem[2];
    int w0 = we_cnt;
    f16(16'h84EE, r);
    f16(16'h9AEE, r);
    f16(16'hD6EE, r);
    f16(16'hBCEE, r);
    chk(we_cnt == w0, "R7 no write strobe", 32'(we_cnt), 32'(w0));
    f16(16'h0400, r);
    f16(16'h0000, r);
    chk(r == keep, "R7 register unchanged", 32'(r), 32'(keep));
    f16(16'hBE10, r);
    chk(we_cnt == w0 + 1 && last_we_addr == 7'h3E, "R2 write-only accepted",
        32'(we_cnt), 32'(w0 + 1));
  endtask

  task automatic t_rsvd_read;
    logic [15:0] r;
    int r0;
    f16(16'h0400, r);
    r0 = re_cnt;
    f16(16'h3000, r);
    chk(re_cnt == r0, "R8 no re reserved", 32'(re_cnt), 32'(r0));
    f16(16'h3E00, r);
    chk(r == 16'h0000, "R8 reserved 0x30 zero", 32'(r), 0);
    f16(16'h7E00, r);
    chk(r == 16'h0000, "R8 write-only 0x3E zero", 32'(r), 0);
    f16(16'h0000, r);
    chk(r == 16'h0000, "R8 reserved 0x7E zero", 32'(r), 0);
    chk(re_cnt == r0 + 1, "R8 re only for 0x00", 32'(re_cnt), 32'(r0 + 1));
  endtask

  task automatic t_short;
    logic [31:0] rx;
    logic [15:0] r;
    int w0 = we_cnt, r0 = re_cnt;
    chk(err == 0, "R9 err clear before", 32'(err), 0);
    xfer({16'h0400, 16'h0}, 10, rx);
    chk(err == 1, "R9 10-bit sets err", 32'(err), 1);
    xfer({16'h92FF, 16'h0}, 12, rx);
    chk(we_cnt == w0 && re_cnt == r0, "R9 partial frame no access",
        {16'(we_cnt), 16'(re_cnt)}, {16'(w0), 16'(r0)});
    f16(16'h0000, r);
    chk(err == 1, "R10 sticky through good frame", 32'(err), 1);
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    @(negedge clk);
    chk(err == 0, "R10 cleared", 32'(err), 0);
    r0 = re_cnt;
    xfer({16'h0000, 16'h0}, 17, rx);
    chk(err == 1, "R9 17-bit sets err", 32'(err), 1);
    chk(re_cnt == r0 + 1, "R9 full frame inside 17 bits acts", 32'(re_cnt), 32'(r0 + 1));
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_double;
    logic [31:0] rx;
    logic [15:0] r;
    xfer({16'h0600, 16'h0000}, 32, rx);
    chk(rx[15:0] == mem[3], "R11 second frame answer", 32'(rx[15:0]), 32'(mem[3]));
    chk(err == 0, "R11 no err on 32 bits", 32'(err), 0);
    f16(16'h0000, r);
    chk(r == mem[0], "R11 trailing request", 32'(r), 32'(mem[0]));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_pipelined();
    t_after_write();
    t_id();
    t_ro_write();
    t_rsvd_read();
    t_short();
    t_double();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule